// File: doc/BRIEF.md
# I2C Master Byte Command Sequencer

This block turns one software command into the string of single-bit operations an I2C master needs for one byte. Software reaches it through a plain register port made of a write strobe, a read strobe, an address and a data bus. It loads a transmit byte, then writes a control word in a single access. The control word holds four request flags (open with a START condition, close with a STOP condition, receive a byte, send a byte) plus the level the master drives in the acknowledge slot of a received byte. A bit-level engine outside the block generates the actual SCL and SDA timing. The sequencer talks to it through a held operation code and a one-cycle completion pulse.

The sequencer is a five-state machine with the states IDLE, START, DATA, ACK and STOP. Its transitions are:
- IDLE goes to START when a START is requested, otherwise to DATA when a byte transfer is requested, otherwise to STOP when only a STOP is requested.
- START goes to DATA, STOP or IDLE on completion, following the same order of choices.
- DATA stays in DATA for eight completions and then goes to ACK.
- ACK goes to STOP if a STOP is requested, otherwise to IDLE.
- STOP goes to IDLE.
- An arbitration loss reported by the engine sends any active state straight back to IDLE.

When a transfer finishes, the request flags are cleared at the same clock edge as the final completion pulse. IDLE therefore never sees a stale START and never issues an unrequested start sequence, which would otherwise show up as an extra SCL pulse ahead of the next data byte. Completion or abort sets a sticky interrupt that stays set until software acknowledges it.

Register map. Address 0: a write loads the transmit byte; a read returns the receive byte. Address 1: a write is the control word; a read returns the status byte.

Top module: `i2cseq_top`

## Requirements
- R1: After reset, `irq` is 0, `eng_cmd` is NOP (0), and a read of either address returns 0.
- R2: A send request produces eight WRITE-bit operations (code 3) whose `eng_din` carries the transmit byte MSB first, then one READ-bit operation (code 4) for the acknowledge slot. A START request (code 1) adds exactly one START in front. No other operation appears.
- R3: A receive request produces eight READ-bit operations (code 4), then one WRITE-bit operation whose `eng_din` equals control bit 3. The eight `eng_dout` values returned on the completion pulses form the receive byte, MSB first, which is readable at address 0.
- R4: When control bits 5 (receive) and 4 (send) are both set, the sequencer performs a receive.
- R5: Control bit 6 appends one STOP operation (code 2) after the acknowledge slot. When no other request flag is set, the STOP is issued on its own.
- R6: On the final completion of a command, the request flags clear in the same cycle. `eng_cmd` then stays NOP until a new command is accepted, and status bit 6 (busy) reads 1 only from acceptance until that completion.
- R7: A control-word write made while busy is ignored and does not change the operation sequence in progress.
- R8: Completion or abort sets `irq` (status bit 0). `irq` stays set until a control write with bit 0 set. If a set and a clear occur in the same cycle, the set wins.
- R9: On a send, the `eng_dout` value seen on the acknowledge-slot completion is stored in status bit 7 (1 means the slave did not acknowledge).
- R10: `eng_arb_lost` during any active operation returns the sequencer to IDLE with the request flags cleared. It sets status bit 5 and `irq`. Status bit 5 clears when the next command is accepted.
- R11: `host_rdata` is registered: it holds the addressed value one cycle after a `host_rd` strobe.
- R12: Each operation code stays constant on `eng_cmd` until its completion pulse or an arbitration loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Register address (0 data, 1 control/status) |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Sticky completion interrupt |
| eng_cmd | output | 3 | Bit operation: 0 NOP, 1 START, 2 STOP, 3 WRITE-bit, 4 READ-bit |
| eng_din | output | 1 | Bit value for WRITE-bit operations |
| eng_done | input | 1 | One-cycle completion pulse from the bit engine |
| eng_dout | input | 1 | Sampled bus bit, valid with `eng_done` |
| eng_arb_lost | input | 1 | Arbitration-loss indication from the bit engine |

## Verification
The assertions check these properties on every cycle:
- Operation codes are held until their completion (R12).
- START follows only NOP.
- The request flags are clear right after a completion, and a quiet idle stays quiet (R6).
- A control write during busy leaves the flags alone (R7).
- The interrupt is sticky and is raised after completion (R8).
- An abort empties the sequencer (R10).

Only the bench scenarios can show the following:
- The exact operation order and data bits of each command type, and READ winning over WRITE.
- Capture of the receive byte and of the slave acknowledge.
- That no spurious operation appears in the idle cycles after a command.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;

    typedef enum logic [2:0] {
        BIT_NOP   = 3'd0,
        BIT_START = 3'd1,
        BIT_STOP  = 3'd2,
        BIT_WRITE = 3'd3,
        BIT_READ  = 3'd4
    } bitop_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_ACK,
        S_STOP
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic wr;
    } req_t;

    // control-word field positions
    localparam int CTL_START = 7;
    localparam int CTL_STOP  = 6;
    localparam int CTL_RD    = 5;
    localparam int CTL_WR    = 4;
    localparam int CTL_ACKV  = 3;
    localparam int CTL_IACK  = 0;

    // status-byte field positions
    localparam int ST_NACK = 7;
    localparam int ST_BUSY = 6;
    localparam int ST_ARB  = 5;
    localparam int ST_IRQ  = 0;

endpackage

// File: rtl/i2cseq_shift.sv
`timescale 1ns/1ps
module i2cseq_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    input  logic              in_bit,
    output logic              msb,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= load_val;
        else if (step)
            sh_q <= {sh_q[DATA_W-2:0], in_bit};
    end

    assign msb   = sh_q[DATA_W-1];
    assign value = sh_q;
endmodule

// File: rtl/i2cseq_regs.sv
`timescale 1ns/1ps
module i2cseq_regs
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              seq_done,
    input  logic              seq_abort,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              nack_vld,
    input  logic              nack_bit,
    output req_t              req,
    output logic              ack_val,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);

    logic              busy, ctl_wr, accept, iack;
    logic              arb_q, nack_q;
    logic [DATA_W-1:0] status;

    assign busy   = |req;
    assign ctl_wr = host_wr && (host_addr == A_CTRL);
    assign accept = ctl_wr && !busy &&
                    (host_wdata[CTL_START] | host_wdata[CTL_STOP] |
                     host_wdata[CTL_RD]    | host_wdata[CTL_WR]);
    assign iack   = ctl_wr && host_wdata[CTL_IACK];

    always_comb begin
        status          = '0;
        status[ST_NACK] = nack_q;
        status[ST_BUSY] = busy;
        status[ST_ARB]  = arb_q;
        status[ST_IRQ]  = irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req        <= '0;
            ack_val    <= 1'b0;
            tx_byte    <= '0;
            arb_q      <= 1'b0;
            nack_q     <= 1'b0;
            irq        <= 1'b0;
            host_rdata <= '0;
        end else begin
            // flags drop together with the final completion pulse
            if (seq_done || seq_abort) begin
                req <= '0;
            end else if (accept) begin
                req.start <= host_wdata[CTL_START];
                req.stop  <= host_wdata[CTL_STOP];
                req.rd    <= host_wdata[CTL_RD];
                req.wr    <= host_wdata[CTL_WR];
                ack_val   <= host_wdata[CTL_ACKV];
            end
            if (host_wr && (host_addr == A_DATA))
                tx_byte <= host_wdata;
            if (seq_abort)
                arb_q <= 1'b1;
            else if (accept)
                arb_q <= 1'b0;
            if (nack_vld)
                nack_q <= nack_bit;
            if (seq_done || seq_abort)
                irq <= 1'b1;
            else if (iack)
                irq <= 1'b0;
            if (host_rd)
                host_rdata <= (host_addr == A_DATA) ? rx_byte : status;
        end
    end
endmodule

// File: rtl/i2cseq_fsm.sv
`timescale 1ns/1ps
module i2cseq_fsm
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  req_t   req,
    input  logic   ack_val,
    input  logic   shift_msb,
    input  logic   eng_done,
    input  logic   eng_dout,
    input  logic   eng_arb_lost,
    output bitop_t eng_cmd,
    output logic   eng_din,
    output logic   launch,
    output logic   bit_step,
    output logic   seq_done,
    output logic   seq_abort,
    output logic   nack_vld,
    output logic   nack_bit
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             fin, xfer;

    assign xfer = req.rd | req.wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state != S_DATA && nxt == S_DATA)
                cnt <= LAST;
            else if (state == S_DATA && eng_done)
                cnt <= cnt - 1'b1;
        end
    end

    // next state and sequencing strobes
    always_comb begin
        nxt = state;
        fin = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (req.start)     nxt = S_START;
                else if (xfer)     nxt = S_DATA;
                else if (req.stop) nxt = S_STOP;
            end
            S_START: begin
                if (eng_done) begin
                    if (xfer)          nxt = S_DATA;
                    else if (req.stop) nxt = S_STOP;
                    else begin nxt = S_IDLE; fin = 1'b1; end
                end
            end
            S_DATA: begin
                if (eng_done && cnt == '0) nxt = S_ACK;
            end
            S_ACK: begin
                if (eng_done) begin
                    if (req.stop) nxt = S_STOP;
                    else begin nxt = S_IDLE; fin = 1'b1; end
                end
            end
            S_STOP: begin
                if (eng_done) begin nxt = S_IDLE; fin = 1'b1; end
            end
            default: nxt = S_IDLE;
        endcase
        seq_abort = (state != S_IDLE) && eng_arb_lost;
        if (seq_abort) nxt = S_IDLE;
        seq_done = fin && !seq_abort;
        launch   = (state == S_IDLE) && (nxt != S_IDLE);
        bit_step = (state == S_DATA) && eng_done && !seq_abort;
        nack_vld = (state == S_ACK) && eng_done && !req.rd && !seq_abort;
        nack_bit = eng_dout;
    end

    // outputs to the bit engine
    always_comb begin
        eng_cmd = BIT_NOP;
        eng_din = 1'b1;
        unique case (state)
            S_IDLE:  eng_cmd = BIT_NOP;
            S_START: eng_cmd = BIT_START;
            S_STOP:  eng_cmd = BIT_STOP;
            S_DATA: begin
                eng_cmd = req.rd ? BIT_READ : BIT_WRITE;
                eng_din = req.rd ? 1'b1 : shift_msb;
            end
            S_ACK: begin
                eng_cmd = req.rd ? BIT_WRITE : BIT_READ;
                eng_din = req.rd ? ack_val : 1'b1;
            end
            default: eng_cmd = BIT_NOP;
        endcase
    end
endmodule

// File: rtl/i2cseq_top.sv
`timescale 1ns/1ps
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq,
    output logic [2:0]        eng_cmd,
    output logic              eng_din,
    input  logic              eng_done,
    input  logic              eng_dout,
    input  logic              eng_arb_lost
);
    req_t              req_q;
    logic [3:0]        req_bits;
    logic              ack_val, shift_msb, launch, bit_step;
    logic              seq_done, seq_abort, nack_vld, nack_bit;
    logic [DATA_W-1:0] tx_byte, rx_byte;
    bitop_t            cmd_e;

    assign req_bits = req_q;
    assign eng_cmd  = cmd_e;

    i2cseq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_done(seq_done), .seq_abort(seq_abort),
        .rx_byte(rx_byte), .nack_vld(nack_vld), .nack_bit(nack_bit),
        .req(req_q), .ack_val(ack_val), .tx_byte(tx_byte), .irq(irq)
    );

    i2cseq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(req_q), .ack_val(ack_val), .shift_msb(shift_msb),
        .eng_done(eng_done), .eng_dout(eng_dout), .eng_arb_lost(eng_arb_lost),
        .eng_cmd(cmd_e), .eng_din(eng_din),
        .launch(launch), .bit_step(bit_step),
        .seq_done(seq_done), .seq_abort(seq_abort),
        .nack_vld(nack_vld), .nack_bit(nack_bit)
    );

    i2cseq_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(launch), .load_val(tx_byte),
        .step(bit_step), .in_bit(eng_dout),
        .msb(shift_msb), .value(rx_byte)
    );
endmodule

// File: rtl/i2cseq_chk.sv
`timescale 1ns/1ps
module i2cseq_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              irq,
    input logic [2:0]        eng_cmd,
    input logic              eng_done,
    input logic              eng_arb_lost,
    input logic [3:0]        req_bits,
    input logic              seq_done
);
    logic iack_wr, ctl_wr;
    assign ctl_wr  = host_wr && (host_addr == ADDR_W'(1));
    assign iack_wr = ctl_wr && host_wdata[0];

    p_cmd_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd != 3'd0 && !eng_done && !eng_arb_lost) |=> (eng_cmd == $past(eng_cmd)));

    p_start_after_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd == 3'd1) |-> ($past(eng_cmd) == 3'd0 || $past(eng_cmd) == 3'd1));

    p_req_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (req_bits == 4'd0));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_bits == 4'd0 && eng_cmd == 3'd0) |=> (eng_cmd == 3'd0));

    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_bits != 4'd0 && ctl_wr) |=> (req_bits == 4'd0 || req_bits == $past(req_bits)));

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !iack_wr) |=> irq);

    p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> irq);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_arb_lost && eng_cmd != 3'd0) |=> (eng_cmd == 3'd0 && irq && req_bits == 4'd0));
endmodule

bind i2cseq_top i2cseq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .irq(irq), .eng_cmd(eng_cmd), .eng_done(eng_done),
    .eng_arb_lost(eng_arb_lost), .req_bits(req_bits), .seq_done(seq_done)
);

// File: tb/i2cseq_top_tb_top.sv
`timescale 1ns/1ps
module i2cseq_top_tb_top;
    localparam int LAT = 3;
    localparam logic [2:0] C_NOP = 3'd0, C_START = 3'd1, C_STOP = 3'd2,
                           C_WR = 3'd3, C_RD = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;
    logic [2:0] eng_cmd;
    logic       eng_din;
    logic       eng_done = 1'b0, eng_dout = 1'b0, eng_arb_lost = 1'b0;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    i2cseq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .eng_cmd(eng_cmd), .eng_din(eng_din), .eng_done(eng_done),
        .eng_dout(eng_dout), .eng_arb_lost(eng_arb_lost)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // behavioural bit engine: acks each held operation after LAT cycles
    bit [3:0] log_q[$];
    bit       rd_bits[$];
    bit       hold_engine = 0;
    int       lat_cnt = 0;
    logic [2:0] held_cmd = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            eng_done = 1'b0;
            lat_cnt  = 0;
        end else if (eng_done) begin
            eng_done = 1'b0;
            lat_cnt  = 0;
        end else if (eng_cmd != C_NOP && !hold_engine) begin
            if (lat_cnt > 0)
                check(eng_cmd == held_cmd, "R12", "operation changed before completion",
                      eng_cmd, held_cmd);
            held_cmd = eng_cmd;
            lat_cnt++;
            if (lat_cnt >= LAT) begin
                eng_done = 1'b1;
                log_q.push_back({eng_cmd, eng_din});
                if (eng_cmd == C_RD && rd_bits.size() > 0)
                    eng_dout = rd_bits.pop_front();
                else
                    eng_dout = 1'b0;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // reference model of busy and interrupt
    bit busy_exp = 0, irq_exp = 0;
    int exp_len = 0, ack_n = 0;

    function automatic int len_of(input logic [7:0] w);
        int n = 0;
        if (w[7]) n++;
        if (w[5] || w[4]) n += 9;
        if (w[6]) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_exp <= 0; irq_exp <= 0; ack_n <= 0; exp_len <= 0;
        end else if (busy_exp && eng_arb_lost) begin
            busy_exp <= 0; irq_exp <= 1; ack_n <= 0;
        end else if (busy_exp && eng_done && ack_n + 1 == exp_len) begin
            busy_exp <= 0; irq_exp <= 1; ack_n <= 0;
        end else begin
            if (eng_done) ack_n <= ack_n + 1;
            if (host_wr && host_addr == 2'd1 && host_wdata[0]) irq_exp <= 0;
            if (!busy_exp && host_wr && host_addr == 2'd1 && |host_wdata[7:4]) begin
                busy_exp <= 1;
                ack_n    <= 0;
                exp_len  <= len_of(host_wdata);
            end
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(irq == irq_exp, "R8", "irq vs model", irq, irq_exp);
            if (!busy_exp)
                check(eng_cmd == C_NOP, "R6", "operation while not busy", eng_cmd, C_NOP);
        end
    end

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    bit [3:0] exp_q[$];

    task automatic build_exp(input logic [7:0] c, input logic [7:0] tx);
        exp_q.delete();
        if (c[7]) exp_q.push_back({C_START, 1'b1});
        if (c[5]) begin
            for (int i = 0; i < 8; i++) exp_q.push_back({C_RD, 1'b1});
            exp_q.push_back({C_WR, c[3]});
        end else if (c[4]) begin
            for (int i = 7; i >= 0; i--) exp_q.push_back({C_WR, tx[i]});
            exp_q.push_back({C_RD, 1'b1});
        end
        if (c[6]) exp_q.push_back({C_STOP, 1'b1});
    endtask

    task automatic wait_idle(input string rq);
        int n = 0;
        while (busy_exp && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n < 5000, rq, "command did not complete", n, 5000);
        repeat (20) @(negedge clk);
    endtask

    task automatic cmp_seq(input string rq);
        bit ok = (log_q.size() == exp_q.size());
        int idx = -1;
        if (ok) begin
            foreach (exp_q[i]) begin
                if (ok && log_q[i] != exp_q[i]) begin
                    ok = 0;
                    idx = i;
                end
            end
        end
        if (!ok && idx >= 0)
            check(0, rq, $sformatf("operation %0d {cmd,din}", idx), log_q[idx], exp_q[idx]);
        else
            check(ok, rq, "operation count", log_q.size(), exp_q.size());
    endtask

    task automatic run_txn(input logic [7:0] c, input logic [7:0] tx, input string rq);
        log_q.delete();
        build_exp(c, tx);
        hwrite(2'd0, tx);
        hwrite(2'd1, c);
        wait_idle(rq);
        cmp_seq(rq);
    endtask

    task automatic load_bits(input logic [7:0] b);
        rd_bits.delete();
        for (int i = 7; i >= 0; i--) rd_bits.push_back(b[i]);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: reset state and registered read port
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);
        check(eng_cmd == C_NOP, "R1", "eng_cmd after reset", eng_cmd, C_NOP);
        hread(2'd1, rv);
        check(rv == 8'h00, "R1", "status after reset", rv, 0);
        hread(2'd0, rv);
        check(rv == 8'h00, "R11", "rx read after reset", rv, 0);

        // R2 / R9: start + send, slave acknowledges
        rd_bits.delete(); rd_bits.push_back(1'b0);
        run_txn(8'h90, 8'hC3, "R2");
        hread(2'd1, rv);
        check(rv[7] == 1'b0, "R9", "ack captured", rv[7], 0);
        check(rv[6] == 1'b0, "R6", "busy cleared", rv[6], 0);
        check(rv[0] == 1'b1 && irq, "R8", "irq set on completion", rv[0], 1);

        // R8: interrupt acknowledge
        hwrite(2'd1, 8'h01);
        @(negedge clk);
        check(irq == 1'b0, "R8", "irq cleared by iack", irq, 0);
        hread(2'd1, rv);
        check(rv == 8'h00, "R8", "status after iack", rv, 0);

        // R5 / R9: send with stop, slave refuses
        rd_bits.delete(); rd_bits.push_back(1'b1);
        run_txn(8'hD0, 8'h5A, "R5");
        hread(2'd1, rv);
        check(rv[7] == 1'b1, "R9", "nack captured", rv[7], 1);

        // R3: start + receive, master nacks
        load_bits(8'hA5);
        run_txn(8'hA8, 8'h00, "R3");
        hread(2'd0, rv);
        check(rv == 8'hA5, "R3", "received byte", rv, 8'hA5);

        // R4: receive and send both requested -> receive
        load_bits(8'h3C);
        run_txn(8'h30, 8'hFF, "R4");
        hread(2'd0, rv);
        check(rv == 8'h3C, "R4", "received byte under priority", rv, 8'h3C);

        // R5: stop alone
        run_txn(8'h40, 8'h00, "R5");

        // R7 / R6: command while busy ignored
        rd_bits.delete(); rd_bits.push_back(1'b0);
        log_q.delete();
        build_exp(8'h90, 8'h81);
        hwrite(2'd0, 8'h81);
        hwrite(2'd1, 8'h90);
        repeat (8) @(negedge clk);
        hread(2'd1, rv);
        check(rv[6] == 1'b1, "R6", "busy during transfer", rv[6], 1);
        hwrite(2'd1, 8'hE0);
        wait_idle("R7");
        cmp_seq("R7");
        hread(2'd1, rv);
        check(rv[6] == 1'b0, "R7", "busy after ignored command", rv[6], 0);

        // R10: arbitration loss aborts
        hwrite(2'd1, 8'h01);
        log_q.delete();
        hold_engine = 1;
        hwrite(2'd1, 8'h90);
        repeat (3) @(negedge clk);
        eng_arb_lost = 1'b1;
        @(negedge clk);
        eng_arb_lost = 1'b0;
        hold_engine = 0;
        repeat (10) @(negedge clk);
        check(log_q.size() == 0, "R10", "operations after abort", log_q.size(), 0);
        hread(2'd1, rv);
        check(rv[5] == 1'b1, "R10", "arb status", rv[5], 1);
        check(rv[6] == 1'b0, "R10", "busy after abort", rv[6], 0);
        check(irq == 1'b1, "R10", "irq after abort", irq, 1);
        hwrite(2'd1, 8'h01);
        run_txn(8'h40, 8'h00, "R10");
        hread(2'd1, rv);
        check(rv[5] == 1'b0, "R10", "arb status cleared by new command", rv[5], 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule